// File: doc/BRIEF.md
# Rational Slot-Pattern Clock Synthesizer

This block builds a core clock whose frequency is a rational multiple P/Q of a reference clock, without a PLL and without a fractional accumulator. Each reference period is split into thirty equal slots, and an external timing source delivers one pulse on `slot_tick` per slot. A constant pattern table, with one pattern per ratio, marks the slots where the core clock toggles. A pattern spans Q reference periods, so even 15/4 comes out exactly. On each tick the block emits the level of the slot it has just processed on `core_clk`. It also emits a fixed 1/1 interface clock on `io_clk`.

A 3-bit select chooses one of eight ratios. The block samples the select only on the tick that processes the first slot of a pattern. Every pattern holds an even number of toggles, so the core clock is low at each pattern boundary, and a ratio change can never leave a runt pulse. `pattern_wrap` pulses for one clock after the tick that processes the last slot of a pattern.

Top module: `rcs_rational_clk_synth`

## Requirements
- R1: While `rst_n` is low, `core_clk`, `io_clk` and `pattern_wrap` are 0, and the first tick after release processes slot 0 of reference period 0.
- R2: After the tick that processes slot s of a reference period (s = 0..29), `io_clk` is 1 for s in 0..14 and 0 for s in 15..29.
- R3: Between consecutive `pattern_wrap` pulses, `core_clk` rises exactly P times, where P is the numerator of the ratio in force.
- R4: After the tick that processes pattern slot n (0 .. 30·Q−1), `core_clk` is 1 when floor(n·P / (15·Q)) is even and 0 when it is odd. For 2/1 this gives high for slots 0–7, low for 8–14, high for 15–22 and low for 23–29.
- R5: `ratio_sel` codes 0..7 select P/Q = 1/1, 3/2, 5/3, 2/1, 5/2, 3/1, 15/4 and 5/1, and a pattern lasts 30·Q ticks.
- R6: The value of `ratio_sel` is taken only on the tick that processes slot 0 of period 0. A change at any other tick has no effect on the pattern in progress.
- R7: `pattern_wrap` is 1 for exactly one clock, the one after the tick that processes the last slot of a pattern, and is 0 otherwise.
- R8: A clock with `slot_tick` low leaves `core_clk`, `io_clk` and the slot position unchanged.
- R9: `core_clk` is 0 whenever `pattern_wrap` is 1, so every ratio change starts from a low level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| slot_tick | input | 1 | One pulse per thirtieth of a reference period |
| ratio_sel | input | 3 | Requested ratio code |
| core_clk | output | 1 | Synthesized core clock level, registered |
| io_clk | output | 1 | 1/1 interface clock level, registered |
| pattern_wrap | output | 1 | One-clock pulse at the end of each pattern |

## Verification
The hardest case to reach from the ports is a select that differs from the running ratio at every tick except the one pattern boundary where it counts. The stimulus drives a different code on every mid-pattern tick and the intended code only when the model stands at slot 0. The eight ratios run back to back, so each boundary also changes the ratio. Sparse ticks, with two idle clocks between ticks, are used on the 15/4, 2/1 and 3/2 patterns, and a reset in the middle of a 15/4 pattern shows that the pattern restarts cleanly.

// File: rtl/rcs_pkg.sv
package rcs_pkg;

  localparam int SLOTS_PER_REF = 30;
  localparam int HALF_SLOTS    = SLOTS_PER_REF / 2;
  localparam int MAX_Q         = 4;
  localparam int NUM_RATIOS    = 8;
  localparam int SEL_W         = $clog2(NUM_RATIOS);
  localparam int SLOT_W        = $clog2(SLOTS_PER_REF);
  localparam int PER_W         = (MAX_Q > 1) ? $clog2(MAX_Q) : 1;
  localparam int QLEN_W        = $clog2(MAX_Q + 1);
  localparam int PAT_DEPTH     = SLOTS_PER_REF * MAX_Q;
  localparam int ADDR_W        = $clog2(PAT_DEPTH);

  // Numerator of the ratio selected by a code.
  function automatic int ratio_num(input int code);
    case (code)
      0:       return 1;
      1:       return 3;
      2:       return 5;
      3:       return 2;
      4:       return 5;
      5:       return 3;
      6:       return 15;
      default: return 5;
    endcase
  endfunction

  // Denominator (pattern length in reference periods).
  function automatic int ratio_den(input int code);
    case (code)
      1:       return 2;
      2:       return 3;
      4:       return 2;
      6:       return 4;
      default: return 1;
    endcase
  endfunction

  // A toggle falls in slot idx when a multiple of HALF_SLOTS*Q/P lands
  // in (idx-1, idx]; non-integer spacings round up to the next slot.
  function automatic bit toggle_at(input int code, input int idx);
    int p;
    int q;
    p = ratio_num(code);
    q = ratio_den(code);
    if (idx >= SLOTS_PER_REF * q) return 1'b0;
    if (idx == 0) return 1'b1;
    return ((idx * p) / (HALF_SLOTS * q)) != (((idx - 1) * p) / (HALF_SLOTS * q));
  endfunction

endpackage

// File: rtl/rcs_slot_seq.sv
module rcs_slot_seq
  import rcs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [QLEN_W-1:0] q_len,
  output logic [SLOT_W-1:0] slot_idx,
  output logic [PER_W-1:0]  period_idx,
  output logic              at_start,
  output logic              at_last
);

  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS_PER_REF - 1);

  logic [SLOT_W-1:0] slot_q, slot_d;
  logic [PER_W-1:0]  period_q, period_d;
  logic              last_period;

  assign last_period = (QLEN_W'(period_q) == (q_len - QLEN_W'(1)));
  assign at_last     = (slot_q == LAST_SLOT) && last_period;
  assign at_start    = (slot_q == '0) && (period_q == '0);

  always_comb begin
    slot_d   = slot_q;
    period_d = period_q;
    if (tick) begin
      if (slot_q == LAST_SLOT) begin
        slot_d   = '0;
        period_d = last_period ? '0 : period_q + PER_W'(1);
      end else begin
        slot_d = slot_q + SLOT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q   <= '0;
      period_q <= '0;
    end else begin
      slot_q   <= slot_d;
      period_q <= period_d;
    end
  end

  assign slot_idx   = slot_q;
  assign period_idx = period_q;

endmodule

// File: rtl/rcs_ratio_hold.sv
module rcs_ratio_hold
  import rcs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              at_start,
  input  logic [SEL_W-1:0]  sel_in,
  output logic [SEL_W-1:0]  sel_eff,
  output logic [SEL_W-1:0]  sel_held,
  output logic [QLEN_W-1:0] q_len
);

  logic [SEL_W-1:0] sel_q, sel_d;
  logic             load_en;

  // The request is honoured only when a new pattern begins.
  assign load_en = tick && at_start;
  assign sel_eff = at_start ? sel_in : sel_q;
  assign q_len   = QLEN_W'(ratio_den(int'(sel_eff)));

  always_comb begin
    sel_d = sel_q;
    if (load_en) sel_d = sel_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= '0;
    else        sel_q <= sel_d;
  end

  assign sel_held = sel_q;

endmodule

// File: rtl/rcs_pattern_rom.sv
module rcs_pattern_rom
  import rcs_pkg::*;
(
  input  logic [SEL_W-1:0]  code,
  input  logic [ADDR_W-1:0] addr,
  output logic              toggle
);

  logic [PAT_DEPTH-1:0] rom_q [NUM_RATIOS];

  for (genvar c = 0; c < NUM_RATIOS; c++) begin : g_ratio
    for (genvar a = 0; a < PAT_DEPTH; a++) begin : g_slot
      localparam logic BIT_V = toggle_at(c, a);
      assign rom_q[c][a] = BIT_V;
    end
  end

  always_comb begin
    toggle = 1'b0;
    if (int'(addr) < PAT_DEPTH) toggle = rom_q[code][addr];
  end

endmodule

// File: rtl/rcs_edge_out.sv
module rcs_edge_out
  import rcs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              toggle,
  input  logic [SLOT_W-1:0] slot_idx,
  input  logic              at_last,
  output logic              core_clk,
  output logic              io_clk,
  output logic              wrap
);

  logic core_q, core_d;
  logic io_q, io_d;
  logic wrap_q, wrap_d;

  always_comb begin
    core_d = core_q;
    io_d   = io_q;
    if (tick) begin
      core_d = core_q ^ toggle;
      io_d   = (slot_idx < SLOT_W'(HALF_SLOTS));
    end
    wrap_d = tick && at_last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      core_q <= 1'b0;
      io_q   <= 1'b0;
      wrap_q <= 1'b0;
    end else begin
      core_q <= core_d;
      io_q   <= io_d;
      wrap_q <= wrap_d;
    end
  end

  assign core_clk = core_q;
  assign io_clk   = io_q;
  assign wrap     = wrap_q;

endmodule

// File: rtl/rcs_rational_clk_synth.sv
module rcs_rational_clk_synth
  import rcs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slot_tick,
  input  logic [SEL_W-1:0] ratio_sel,
  output logic             core_clk,
  output logic             io_clk,
  output logic             pattern_wrap
);

  logic [SLOT_W-1:0] slot_idx;
  logic [PER_W-1:0]  period_idx;
  logic              at_start;
  logic              at_last;
  logic [SEL_W-1:0]  sel_eff;
  logic [SEL_W-1:0]  sel_held;
  logic [QLEN_W-1:0] q_len;
  logic [ADDR_W-1:0] rom_addr;
  logic              toggle;

  rcs_slot_seq i_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (slot_tick),
    .q_len      (q_len),
    .slot_idx   (slot_idx),
    .period_idx (period_idx),
    .at_start   (at_start),
    .at_last    (at_last)
  );

  rcs_ratio_hold i_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (slot_tick),
    .at_start (at_start),
    .sel_in   (ratio_sel),
    .sel_eff  (sel_eff),
    .sel_held (sel_held),
    .q_len    (q_len)
  );

  assign rom_addr = ADDR_W'(period_idx) * ADDR_W'(SLOTS_PER_REF) + ADDR_W'(slot_idx);

  rcs_pattern_rom i_rom (
    .code   (sel_eff),
    .addr   (rom_addr),
    .toggle (toggle)
  );

  rcs_edge_out i_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (slot_tick),
    .toggle   (toggle),
    .slot_idx (slot_idx),
    .at_last  (at_last),
    .core_clk (core_clk),
    .io_clk   (io_clk),
    .wrap     (pattern_wrap)
  );

endmodule

// File: rtl/rcs_checker.sv
module rcs_checker
  import rcs_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              slot_tick,
  input logic              core_clk,
  input logic              io_clk,
  input logic              pattern_wrap,
  input logic              at_start,
  input logic [SEL_W-1:0]  sel_held,
  input logic [SLOT_W-1:0] slot_idx
);

  assert_io_rise_after_slot0_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(io_clk) |-> (slot_idx == SLOT_W'(1)));

  assert_select_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_tick && !at_start) |=> $stable(sel_held));

  assert_wrap_at_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pattern_wrap |-> at_start);

  assert_wrap_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pattern_wrap |=> !pattern_wrap);

  assert_hold_no_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_tick |=> ($stable(core_clk) && $stable(io_clk) && $stable(slot_idx)));

  assert_core_low_at_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pattern_wrap |-> !core_clk);

endmodule

bind rcs_rational_clk_synth rcs_checker i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .slot_tick    (slot_tick),
  .core_clk     (core_clk),
  .io_clk       (io_clk),
  .pattern_wrap (pattern_wrap),
  .at_start     (at_start),
  .sel_held     (sel_held),
  .slot_idx     (slot_idx)
);

// File: tb/test_rcs_rational_clk_synth.sv
module test_rcs_rational_clk_synth;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       slot_tick;
  logic [2:0] ratio_sel;
  wire        core_clk;
  wire        io_clk;
  wire        pattern_wrap;

  always #5 clk = ~clk;

  rcs_rational_clk_synth i_rcs_rational_clk_synth (
    .clk          (clk),
    .rst_n        (rst_n),
    .slot_tick    (slot_tick),
    .ratio_sel    (ratio_sel),
    .core_clk     (core_clk),
    .io_clk       (io_clk),
    .pattern_wrap (pattern_wrap)
  );

  int tp [8] = '{1, 3, 5, 2, 5, 3, 15, 5};
  int tq [8] = '{1, 2, 3, 1, 2, 1, 4, 1};

  int errors = 0;
  int checks = 0;
  int pos = 0;
  int ap = 1;
  int aq = 1;
  bit e_core = 0;
  bit e_io = 0;
  bit e_wrap = 0;
  int rises = 0;
  int ticks_in = 0;
  bit prev_core = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    pos = 0; e_core = 0; e_io = 0; e_wrap = 0;
    rises = 0; ticks_in = 0; prev_core = 0;
  endtask

  // Behavioural expectation for the edge that follows.
  task automatic model(input bit t, input int s);
    if (!rst_n) return;
    if (t) begin
      if (pos == 0) begin ap = tp[s]; aq = tq[s]; end
      e_core = (((pos * ap) / (15 * aq)) % 2) == 0;
      e_io   = (pos % 30) < 15;
      e_wrap = (pos == 30 * aq - 1);
      pos    = (pos + 1) % (30 * aq);
    end else begin
      e_wrap = 0;
    end
  endtask

  task automatic compare(input bit t);
    string rq;
    if (!rst_n) rq = "R1"; else if (!t) rq = "R8"; else rq = "R4";
    chk(core_clk === e_core, rq, "core_clk", int'(core_clk), int'(e_core));
    if (rst_n && t) rq = "R2";
    chk(io_clk === e_io, rq, "io_clk", int'(io_clk), int'(e_io));
    if (rst_n) rq = "R7";
    chk(pattern_wrap === e_wrap, rq, "pattern_wrap", int'(pattern_wrap), int'(e_wrap));
    if (!rst_n) return;
    if (core_clk && !prev_core) rises++;
    prev_core = core_clk;
    if (t) ticks_in++;
    if (pattern_wrap) begin
      chk(rises == ap, "R3", "core rises per pattern", rises, ap);
      chk(ticks_in == 30 * aq, "R5", "slots per pattern", ticks_in, 30 * aq);
      chk(core_clk == 1'b0, "R9", "core level at wrap", int'(core_clk), 0);
      rises = 0;
      ticks_in = 0;
    end
  endtask

  task automatic step(input bit t, input int s);
    slot_tick = t;
    ratio_sel = 3'(s);
    model(t, s);
    @(posedge clk);
    @(negedge clk);
    compare(t);
  endtask

  // Intended code at pattern start, a different one elsewhere (R6).
  function automatic int pick(input int c, input int i);
    return (pos == 0) ? c : (c + 1 + (i % 7)) % 8;
  endfunction

  task automatic finish_run();
    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    rst_n = 1'b0;
    slot_tick = 1'b0;
    ratio_sel = 3'd0;
    model_reset();
    // R1: reset state, ticks ignored while held
    for (int i = 0; i < 4; i++) step(1'b1, 5);
    rst_n = 1'b1;

    // R5 R6: every ratio, two patterns each, select disturbed mid-pattern
    for (int c = 0; c < 8; c++) begin
      for (int i = 0; i < 60 * tq[c]; i++) step(1'b1, pick(c, i));
    end

    // R8: sparse ticks on 15/4, 2/1 and 3/2
    for (int k = 0; k < 3; k++) begin
      int c;
      c = (k == 0) ? 6 : ((k == 1) ? 3 : 1);
      for (int i = 0; i < 180 * tq[c]; i++) step((i % 3) == 0, pick(c, i));
    end

    // R1: reset in the middle of a 15/4 pattern
    for (int i = 0; i < 50; i++) step(1'b1, pick(6, i));
    rst_n = 1'b0;
    #1;
    chk(core_clk == 1'b0 && io_clk == 1'b0 && pattern_wrap == 1'b0, "R1",
        "outputs during mid-run reset", int'({core_clk, io_clk, pattern_wrap}), 0);
    model_reset();
    for (int i = 0; i < 3; i++) step(1'b1, 6);
    rst_n = 1'b1;
    for (int i = 0; i < 60; i++) step(1'b1, pick(7, i));
    for (int i = 0; i < 180; i++) step(1'b1, pick(2, i));
    for (int i = 0; i < 4; i++) step(1'b0, 0);

    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      finish_run();
    end
  end

endmodule